// File: doc/BRIEF.md
# Load/Store Watchpoint Match Unit

This debug block observes every access on a core's load/store path and decides whether it matches a programmed condition. Two magnitude comparators look at the access address and two at the access data. Each comparator applies its own relation (equal, not equal, greater, less, greater-or-equal, less-or-equal, or ignore). The data comparators also pick the operand width, drop selected byte lanes from the comparison, and can treat operands as two's complement. For every access the unit reports which of its two watchpoints fired and whether a breakpoint trap follows, with the trap routed to a maskable or a non-maskable output.

Each watchpoint names one address comparator and one data comparator, enables either contribution, and joins them with AND or OR. A trap is raised either on every hit of a watchpoint, or by a countdown that is loaded with N, tied to one watchpoint, and fires once on the Nth hit. An always-true boundary relation, such as unsigned greater-or-equal to zero, is expressed with the ignore relation.

Programming goes through a single-cycle write port holding seven registers: address references at index 0 and 1, data references at 2 and 3, the comparator control word at 4, the watchpoint control word at 5 and the countdown load at 6.

Top module: `lsw_match_unit`

## Requirements
- R1: After reset both watchpoint outputs and both trap outputs are 0, every watchpoint is disabled and the countdown is idle, so a matching access raises nothing.
- R2: Each comparator evaluates "bus value REL reference" with the 3-bit relation code 0 equal, 1 not equal, 2 greater, 3 less, 4 greater-or-equal, 5 less-or-equal, 6 ignore (always true); in the control word the relation of address comparator k sits at bits [3k+2:3k] and that of data comparator j at bits [3j+8:3j+6]. Address compares are unsigned.
- R3: Data comparator j has a 7-bit lane field at control-word bits [7j+18:7j+12]: size in the low two bits (0 byte, 1 halfword, 2 or 3 word), the signed flag next, and a 4-bit lane mask on top in which bit i set removes byte lane i (bits [8i+7:8i]) from the comparison. Lanes above the size are ignored, and data is right-aligned.
- R4: With the signed flag set, both operands are sign-extended from the top bit of the selected size (after lane masking) and compared as two's complement; with it clear they compare as unsigned.
- R5: Watchpoint w takes control-word-5 bits [8w+6:8w]: bit0 enable, bit1 address comparator select, bit2 data comparator select, bit3 address enable, bit4 data enable, bit5 join (0 AND, 1 OR), bit6 trap on every hit. In AND mode every enabled contribution must match; in OR mode any enabled one; with neither contribution enabled the watchpoint never hits.
- R6: A watchpoint whose enable bit is clear never raises its output.
- R7: A hit of a watchpoint with its trap-on-every-hit bit set raises a trap; bit 16 of control word 5 routes every trap to trap_nmi when set and to trap_mask when clear, and only one of the two is raised.
- R8: Writing N to register 6 arms the countdown for the watchpoint chosen by control-word-5 bit 17; each hit of that watchpoint counts down, the Nth hit raises a trap for exactly one cycle, and further hits raise nothing until it is reloaded. Loading 0 leaves it idle.
- R9: Watchpoint and trap outputs are registered: they reflect the access sampled with ls_valid high at the previous rising edge, and are 0 in a cycle after ls_valid was low.
- R10: Relation code 7 behaves as ignore (always true).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register index |
| cfg_wdata | input | CFG_W | Register write data |
| ls_valid | input | 1 | A load/store access is present |
| ls_addr | input | ADDR_W | Access address |
| ls_data | input | DATA_W | Access data, right-aligned |
| wp_event | output | 2 | Per-watchpoint hit, one cycle after the access |
| trap_mask | output | 1 | Maskable breakpoint trap |
| trap_nmi | output | 1 | Non-maskable breakpoint trap |

## Verification
Every result of this unit (both watchpoint flags and both trap lines) is due exactly one rising edge after the access is presented with ls_valid high, and a register write takes effect for an access sampled at the following edge. The bench therefore drives an access on a falling edge, lets one rising edge pass, and reads all four outputs shortly after that edge, then confirms they drop at the next edge when no access is presented. For the countdown it checks the trap after each hit individually, so that the one-cycle pulse on the Nth hit and the silence on the hits around it are each seen in their own cycle.

// File: rtl/lsw_pkg.sv
package lsw_pkg;

   // relation codes of a comparator
   typedef enum logic [2:0] {
      REL_EQ  = 3'd0,
      REL_NE  = 3'd1,
      REL_GT  = 3'd2,
      REL_LT  = 3'd3,
      REL_GE  = 3'd4,
      REL_LE  = 3'd5,
      REL_ANY = 3'd6
   } rel_e;

   // lane setup of one data comparator (7 bits, size in the low bits)
   typedef struct packed {
      logic [3:0] lane_off;
      logic       is_signed;
      logic [1:0] size;
   } lane_cfg_t;

   // control of one watchpoint (7 bits, enable in bit 0)
   typedef struct packed {
      logic every;
      logic join_or;
      logic dat_en;
      logic adr_en;
      logic dat_sel;
      logic adr_sel;
      logic enable;
   } wp_cfg_t;

   localparam int LANE_CFG_W = $bits(lane_cfg_t);
   localparam int WP_CFG_W   = $bits(wp_cfg_t);

endpackage

// File: rtl/lsw_lane_prep.sv
module lsw_lane_prep
   import lsw_pkg::*;
#(
   parameter int W = 32
) (
   input  logic [W-1:0] val,
   input  lane_cfg_t    cfg,
   output logic [W:0]   ext
);
   localparam int NB = W / 8;

   logic [NB-1:0] in_size;
   logic [W-1:0]  kept;
   logic [W-1:0]  fill;
   logic          sign;

   always_comb begin
      for (int i = 0; i < NB; i++) begin
         case (cfg.size)
            2'd0:    in_size[i] = (i < 1);
            2'd1:    in_size[i] = (i < 2);
            default: in_size[i] = 1'b1;
         endcase
         kept[i*8 +: 8] = (in_size[i] && !cfg.lane_off[i]) ? val[i*8 +: 8] : 8'h00;
      end
      case (cfg.size)
         2'd0:    sign = kept[7];
         2'd1:    sign = kept[15];
         default: sign = kept[W-1];
      endcase
      sign = sign & cfg.is_signed;
      for (int i = 0; i < NB; i++)
         fill[i*8 +: 8] = (!in_size[i] && sign) ? 8'hFF : 8'h00;
      ext = {sign, kept | fill};
   end
endmodule

// File: rtl/lsw_cmp.sv
module lsw_cmp
   import lsw_pkg::*;
#(
   parameter int W = 32
) (
   input  logic [W:0] a,
   input  logic [W:0] b,
   input  logic [2:0] rel,
   output logic       match
);
   logic eq, lt;

   always_comb begin
      eq = (a == b);
      lt = ($signed(a) < $signed(b));
      case (rel)
         REL_EQ:  match = eq;
         REL_NE:  match = !eq;
         REL_GT:  match = !lt && !eq;
         REL_LT:  match = lt;
         REL_GE:  match = !lt;
         REL_LE:  match = lt || eq;
         default: match = 1'b1;
      endcase
   end
endmodule

// File: rtl/lsw_wp_join.sv
module lsw_wp_join
   import lsw_pkg::*;
#(
   parameter int N_A = 2,
   parameter int N_D = 2
) (
   input  logic [N_A-1:0] a_hit,
   input  logic [N_D-1:0] d_hit,
   input  wp_cfg_t        cfg,
   output logic           hit
);
   logic ah, dh, any_src, joined;

   always_comb begin
      ah      = a_hit[cfg.adr_sel];
      dh      = d_hit[cfg.dat_sel];
      any_src = cfg.adr_en | cfg.dat_en;
      if (cfg.join_or)
         joined = (cfg.adr_en & ah) | (cfg.dat_en & dh);
      else
         joined = (!cfg.adr_en | ah) & (!cfg.dat_en | dh);
      hit = cfg.enable & any_src & joined;
   end
endmodule

// File: rtl/lsw_countdown.sv
module lsw_countdown #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             hit,
   output logic             fire,
   output logic [CNT_W-1:0] count
);
   logic armed;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count <= '0;
         armed <= 1'b0;
      end else if (load) begin
         count <= load_val;
         armed <= (load_val != '0);
      end else if (armed && hit) begin
         count <= count - 1'b1;
         if (count == CNT_W'(1)) armed <= 1'b0;
      end
   end

   assign fire = armed && hit && !load && (count == CNT_W'(1));
endmodule

// File: rtl/lsw_match_unit.sv
module lsw_match_unit
   import lsw_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int CNT_W  = 16,
   parameter int CFG_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [2:0]        cfg_addr,
   input  logic [CFG_W-1:0]  cfg_wdata,
   input  logic              ls_valid,
   input  logic [ADDR_W-1:0] ls_addr,
   input  logic [DATA_W-1:0] ls_data,
   output logic [1:0]        wp_event,
   output logic              trap_mask,
   output logic              trap_nmi
);
   localparam int N_A   = 2;
   localparam int N_D   = 2;
   localparam int N_WP  = 2;
   localparam int N_CMP = N_A + N_D;
   localparam int REL_W = 3;
   localparam int LANE_BASE = N_CMP * REL_W;
   localparam logic [2:0] IDX_AREF = 3'd0;
   localparam logic [2:0] IDX_DREF = 3'd2;
   localparam logic [2:0] IDX_CMP  = 3'd4;
   localparam logic [2:0] IDX_WP   = 3'd5;
   localparam logic [2:0] IDX_CNT  = 3'd6;
   localparam int BIT_NMI = 16;
   localparam int BIT_SEL = 17;

   initial begin : param_chk
      assert (DATA_W == 32) else $error("DATA_W must be 32 for four byte lanes");
      assert (ADDR_W <= CFG_W && DATA_W <= CFG_W) else $error("reference wider than CFG_W");
      assert (CNT_W <= CFG_W && CFG_W > BIT_SEL) else $error("CFG_W too narrow");
      assert (LANE_BASE + N_D * LANE_CFG_W <= CFG_W) else $error("lane fields exceed CFG_W");
   end

   logic [ADDR_W-1:0] aref_q  [N_A];
   logic [DATA_W-1:0] dref_q  [N_D];
   logic [REL_W-1:0]  rel_q   [N_CMP];
   lane_cfg_t         lane_q  [N_D];
   wp_cfg_t           wp_q    [N_WP];
   logic              nonmask_q;
   logic              cnt_sel_q;

   // ---------------- register file ----------------
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < N_A; i++) aref_q[i] <= '0;
         for (int i = 0; i < N_D; i++) begin
            dref_q[i] <= '0;
            lane_q[i] <= '0;
         end
         for (int i = 0; i < N_CMP; i++) rel_q[i] <= '0;
         for (int i = 0; i < N_WP; i++)  wp_q[i]  <= '0;
         nonmask_q <= 1'b0;
         cnt_sel_q <= 1'b0;
      end else if (cfg_we) begin
         for (int i = 0; i < N_A; i++)
            if (cfg_addr == IDX_AREF + 3'(i)) aref_q[i] <= cfg_wdata[ADDR_W-1:0];
         for (int i = 0; i < N_D; i++)
            if (cfg_addr == IDX_DREF + 3'(i)) dref_q[i] <= cfg_wdata[DATA_W-1:0];
         if (cfg_addr == IDX_CMP) begin
            for (int i = 0; i < N_CMP; i++) rel_q[i] <= cfg_wdata[i*REL_W +: REL_W];
            for (int i = 0; i < N_D; i++)
               lane_q[i] <= lane_cfg_t'(cfg_wdata[LANE_BASE + i*LANE_CFG_W +: LANE_CFG_W]);
         end
         if (cfg_addr == IDX_WP) begin
            for (int i = 0; i < N_WP; i++) wp_q[i] <= wp_cfg_t'(cfg_wdata[i*8 +: WP_CFG_W]);
            nonmask_q <= cfg_wdata[BIT_NMI];
            cnt_sel_q <= cfg_wdata[BIT_SEL];
         end
      end
   end

   // ---------------- comparators ----------------
   logic [N_A-1:0] a_hit;
   logic [N_D-1:0] d_hit;

   for (genvar g = 0; g < N_CMP; g++) begin : g_cmp
      if (g < N_A) begin : g_adr
         lsw_cmp #(.W(ADDR_W)) u_cmp (
            .a     ({1'b0, ls_addr}),
            .b     ({1'b0, aref_q[g]}),
            .rel   (rel_q[g]),
            .match (a_hit[g])
         );
      end else begin : g_dat
         localparam int J = g - N_A;
         logic [DATA_W:0] bus_x, ref_x;
         lsw_lane_prep #(.W(DATA_W)) u_bus (.val(ls_data),   .cfg(lane_q[J]), .ext(bus_x));
         lsw_lane_prep #(.W(DATA_W)) u_ref (.val(dref_q[J]), .cfg(lane_q[J]), .ext(ref_x));
         lsw_cmp #(.W(DATA_W)) u_cmp (
            .a     (bus_x),
            .b     (ref_x),
            .rel   (rel_q[g]),
            .match (d_hit[J])
         );
      end
   end

   // ---------------- watchpoints ----------------
   logic [N_WP-1:0] wp_raw, wp_hit, wp_every, wp_en_vec, wp_src_vec;

   for (genvar w = 0; w < N_WP; w++) begin : g_wp
      lsw_wp_join #(.N_A(N_A), .N_D(N_D)) u_join (
         .a_hit (a_hit),
         .d_hit (d_hit),
         .cfg   (wp_q[w]),
         .hit   (wp_raw[w])
      );
      assign wp_hit[w]     = wp_raw[w] & ls_valid;
      assign wp_every[w]   = wp_q[w].every;
      assign wp_en_vec[w]  = wp_q[w].enable;
      assign wp_src_vec[w] = wp_q[w].adr_en | wp_q[w].dat_en;
   end

   // ---------------- countdown and traps ----------------
   logic             cnt_load, cnt_fire;
   logic [CNT_W-1:0] cnt_count;
   logic             trap_raw;

   assign cnt_load = cfg_we && (cfg_addr == IDX_CNT);

   lsw_countdown #(.CNT_W(CNT_W)) u_count (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (cnt_load),
      .load_val (cfg_wdata[CNT_W-1:0]),
      .hit      (wp_hit[cnt_sel_q]),
      .fire     (cnt_fire),
      .count    (cnt_count)
   );

   assign trap_raw = (|(wp_hit & wp_every)) | cnt_fire;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp_event  <= '0;
         trap_mask <= 1'b0;
         trap_nmi  <= 1'b0;
      end else begin
         wp_event  <= wp_hit;
         trap_mask <= trap_raw & !nonmask_q;
         trap_nmi  <= trap_raw & nonmask_q;
      end
   end
endmodule

// File: rtl/lsw_match_unit_chk.sv
module lsw_match_unit_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ls_valid,
   input logic [1:0]       wp_event,
   input logic             trap_mask,
   input logic             trap_nmi,
   input logic [1:0]       wp_en_vec,
   input logic [1:0]       wp_src_vec,
   input logic             nonmask_q,
   input logic             cnt_load,
   input logic [CNT_W-1:0] cnt_count
);
   // R9
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(ls_valid) |-> (wp_event == 2'b00 && !trap_mask && !trap_nmi));

   // R6
   wp0_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wp_event[0] |-> $past(wp_en_vec[0]));

   // R6
   wp1_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wp_event[1] |-> $past(wp_en_vec[1]));

   // R5
   wp_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      |(wp_event & ~$past(wp_src_vec)) |-> 1'b0);

   // R7
   trap_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_nmi |-> $past(nonmask_q)) and (trap_mask |-> !$past(nonmask_q)));

   // R8
   count_down_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(cnt_load) |-> (cnt_count <= $past(cnt_count)));
endmodule

bind lsw_match_unit lsw_match_unit_chk #(.CNT_W(CNT_W)) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ls_valid   (ls_valid),
   .wp_event   (wp_event),
   .trap_mask  (trap_mask),
   .trap_nmi   (trap_nmi),
   .wp_en_vec  (wp_en_vec),
   .wp_src_vec (wp_src_vec),
   .nonmask_q  (nonmask_q),
   .cnt_load   (cnt_load),
   .cnt_count  (cnt_count)
);

// File: tb/test_lsw_match_unit.sv
`timescale 1ns/1ps
module test_lsw_match_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic        ls_valid = 1'b0;
   logic [31:0] ls_addr = '0;
   logic [31:0] ls_data = '0;
   logic [1:0]  wp_event;
   logic        trap_mask, trap_nmi;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   lsw_match_unit i_lsw_match_unit (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .ls_valid(ls_valid), .ls_addr(ls_addr),
      .ls_data(ls_data), .wp_event(wp_event), .trap_mask(trap_mask),
      .trap_nmi(trap_nmi)
   );

   // relation codes (R2, R10)
   localparam logic [2:0] EQ = 3'd0, NE = 3'd1, GT = 3'd2, LT = 3'd3,
                          GE = 3'd4, LE = 3'd5, IG = 3'd6, RS = 3'd7;

   function automatic logic [6:0] lane(input logic [1:0] sz, input logic sg, input logic [3:0] off);
      return {off, sg, sz};
   endfunction

   function automatic logic [31:0] ctl(input logic [2:0] a0, input logic [2:0] a1,
                                       input logic [2:0] d0, input logic [2:0] d1,
                                       input logic [6:0] l0, input logic [6:0] l1);
      return {6'b0, l1, l0, d1, d0, a1, a0};
   endfunction

   function automatic logic [6:0] wp(input logic en, input logic as, input logic ds,
                                     input logic ae, input logic de, input logic orm,
                                     input logic ev);
      return {ev, orm, de, ae, ds, as, en};
   endfunction

   function automatic logic [31:0] wpw(input logic [6:0] w0, input logic [6:0] w1,
                                       input logic nmi, input logic sel);
      return {14'b0, sel, nmi, 1'b0, w1, 1'b0, w0};
   endfunction

   typedef struct packed {
      logic [3:0]  req;
      logic [31:0] c;
      logic [31:0] w;
      logic [31:0] a;
      logic [31:0] d;
      logic [3:0]  exp;   // {wp_event[1:0], trap_mask, trap_nmi}
   } vec_t;

   localparam logic [6:0] W_A0 = wp(1, 0, 0, 1, 0, 0, 1);
   localparam logic [6:0] W_A1 = wp(1, 1, 0, 1, 0, 0, 1);
   localparam logic [6:0] W_D0 = wp(1, 0, 0, 0, 1, 0, 1);
   localparam logic [6:0] W_D1 = wp(1, 0, 1, 0, 1, 0, 1);
   localparam logic [6:0] W_AD = wp(1, 0, 0, 1, 1, 0, 1);
   localparam logic [6:0] W_OR = wp(1, 0, 0, 1, 1, 1, 1);
   localparam logic [6:0] L_B  = lane(2'd0, 1'b0, 4'b0000);

   localparam int NV = 23;
   // references: addr0 0x1000, addr1 0x2000, data0 0x80, data1 0x12345678
   localparam vec_t VECS [NV] = '{
      '{4'd2,  ctl(EQ, IG, IG, IG, 0, 0), wpw(W_A0, 0, 0, 0), 32'h1000, 32'h0, 4'b0110}, // R2 eq
      '{4'd2,  ctl(NE, IG, IG, IG, 0, 0), wpw(W_A0, 0, 0, 0), 32'h1000, 32'h0, 4'b0000}, // R2 ne
      '{4'd2,  ctl(GT, IG, IG, IG, 0, 0), wpw(W_A0, 0, 0, 0), 32'h1001, 32'h0, 4'b0110}, // R2 gt
      '{4'd2,  ctl(LT, IG, IG, IG, 0, 0), wpw(W_A0, 0, 0, 0), 32'h1001, 32'h0, 4'b0000}, // R2 lt
      '{4'd2,  ctl(GE, IG, IG, IG, 0, 0), wpw(W_A0, 0, 0, 0), 32'h1000, 32'h0, 4'b0110}, // R2 ge
      '{4'd2,  ctl(IG, LE, IG, IG, 0, 0), wpw(W_A1, 0, 0, 0), 32'h1FFF, 32'h0, 4'b0110}, // R2 le
      '{4'd2,  ctl(IG, LT, IG, IG, 0, 0), wpw(W_A1, 0, 0, 0), 32'h2000, 32'h0, 4'b0000}, // R2 lt equal
      '{4'd3,  ctl(IG, IG, EQ, IG, L_B, 0), wpw(W_D0, 0, 0, 0), 32'h0, 32'hABCDEF80, 4'b0110}, // R3 byte
      '{4'd4,  ctl(IG, IG, GT, IG, lane(0, 1, 0), 0), wpw(W_D0, 0, 0, 0), 32'h0, 32'h01, 4'b0110}, // R4 signed
      '{4'd4,  ctl(IG, IG, GT, IG, L_B, 0), wpw(W_D0, 0, 0, 0), 32'h0, 32'h01, 4'b0000},        // R4 unsigned
      '{4'd3,  ctl(IG, IG, IG, EQ, 0, lane(2, 0, 4'b0010)), wpw(W_D1, 0, 0, 0), 32'h0, 32'h12340078, 4'b0110}, // R3 mask
      '{4'd3,  ctl(IG, IG, IG, EQ, 0, lane(2, 0, 4'b0010)), wpw(W_D1, 0, 0, 0), 32'h0, 32'h12350078, 4'b0000}, // R3 kept lane differs
      '{4'd3,  ctl(IG, IG, IG, EQ, 0, lane(1, 0, 0)), wpw(W_D1, 0, 0, 0), 32'h0, 32'hFFFF5678, 4'b0110},       // R3 half
      '{4'd5,  ctl(EQ, IG, EQ, IG, L_B, 0), wpw(W_AD, 0, 0, 0), 32'h1000, 32'h00, 4'b0000}, // R5 and
      '{4'd5,  ctl(EQ, IG, EQ, IG, L_B, 0), wpw(W_OR, 0, 0, 0), 32'h1000, 32'h00, 4'b0110}, // R5 or
      '{4'd5,  ctl(EQ, IG, EQ, IG, L_B, 0), wpw(W_AD, 0, 0, 0), 32'h1000, 32'h80, 4'b0110}, // R5 and both
      '{4'd5,  ctl(EQ, EQ, IG, IG, 0, 0), wpw(W_A0, wp(1, 1, 0, 1, 0, 0, 0), 0, 0), 32'h2000, 32'h0, 4'b1000}, // R5 second wp
      '{4'd10, ctl(RS, IG, IG, IG, 0, 0), wpw(W_A0, 0, 0, 0), 32'h5555, 32'h0, 4'b0110}, // R10 code 7
      '{4'd6,  ctl(EQ, IG, IG, IG, 0, 0), wpw(wp(0, 0, 0, 1, 0, 0, 1), 0, 0, 0), 32'h1000, 32'h0, 4'b0000}, // R6
      '{4'd5,  ctl(EQ, IG, IG, IG, 0, 0), wpw(wp(1, 0, 0, 0, 0, 0, 1), 0, 0, 0), 32'h1000, 32'h0, 4'b0000}, // R5 no source
      '{4'd7,  ctl(EQ, IG, IG, IG, 0, 0), wpw(W_A0, 0, 1, 0), 32'h1000, 32'h0, 4'b0101}, // R7 nmi
      '{4'd4,  ctl(IG, IG, LE, IG, lane(2, 1, 0), 0), wpw(W_D0, 0, 0, 0), 32'h0, 32'hFFFFFFFF, 4'b0110}, // R4 word signed
      '{4'd4,  ctl(IG, IG, LE, IG, lane(2, 0, 0), 0), wpw(W_D0, 0, 0, 0), 32'h0, 32'hFFFFFFFF, 4'b0000}  // R4 word unsigned
   };

   task automatic wr(input logic [2:0] idx, input logic [31:0] val);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = idx; cfg_wdata = val;
      @(posedge clk); #1;
      cfg_we = 1'b0;
   endtask

   task automatic access(input logic v, input logic [31:0] a, input logic [31:0] d);
      @(negedge clk);
      ls_valid = v; ls_addr = a; ls_data = d;
      @(posedge clk); #1;
      ls_valid = 1'b0;
   endtask

   task automatic check(input string req, input logic [3:0] exp);
      logic [3:0] got;
      got = {wp_event, trap_mask, trap_nmi};
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: {wp,trapm,trapn} actual %b expected %b", req, got, exp);
      end
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      check("R1 reset", 4'b0000);
      rst_n = 1'b1;
      wr(3'd0, 32'h1000);
      wr(3'd1, 32'h2000);
      wr(3'd2, 32'h80);
      wr(3'd3, 32'h12345678);
      // R1: default control leaves every watchpoint off
      access(1'b1, 32'h0, 32'h0);
      check("R1 idle after reset", 4'b0000);

      for (int i = 0; i < NV; i++) begin
         wr(3'd4, VECS[i].c);
         wr(3'd5, VECS[i].w);
         access(1'b1, VECS[i].a, VECS[i].d);
         check($sformatf("R%0d vector %0d", VECS[i].req, i), VECS[i].exp);
      end

      // R9: matching address but no valid raises nothing
      wr(3'd4, ctl(EQ, IG, IG, IG, 0, 0));
      wr(3'd5, wpw(W_A0, 0, 0, 0));
      access(1'b0, 32'h1000, 32'h0);
      check("R9 valid low", 4'b0000);
      access(1'b1, 32'h1000, 32'h0);
      check("R9 registered hit", 4'b0110);
      @(posedge clk); #1;
      check("R9 one cycle only", 4'b0000);

      // R8: trap on the third hit of watchpoint 0 only
      wr(3'd5, wpw(wp(1, 0, 0, 1, 0, 0, 0), 0, 0, 0));
      wr(3'd6, 32'd3);
      access(1'b1, 32'h1000, 32'h0);
      check("R8 hit 1", 4'b0100);
      access(1'b1, 32'h1000, 32'h0);
      check("R8 hit 2", 4'b0100);
      access(1'b1, 32'h1000, 32'h0);
      check("R8 hit 3 traps", 4'b0110);
      @(posedge clk); #1;
      check("R8 pulse ends", 4'b0000);
      access(1'b1, 32'h1000, 32'h0);
      check("R8 stopped after fire", 4'b0100);
      // R8: countdown on watchpoint 1 ignores watchpoint 0 hits
      wr(3'd4, ctl(EQ, EQ, IG, IG, 0, 0));
      wr(3'd5, wpw(wp(1, 0, 0, 1, 0, 0, 0), wp(1, 1, 0, 1, 0, 0, 0), 1, 1));
      wr(3'd6, 32'd1);
      access(1'b1, 32'h1000, 32'h0);
      check("R8 other watchpoint no count", 4'b0100);
      access(1'b1, 32'h2000, 32'h0);
      check("R8 N=1 nmi trap", 4'b1001);
      // R8: load of zero stays idle
      wr(3'd6, 32'd0);
      access(1'b1, 32'h2000, 32'h0);
      check("R8 zero load idle", 4'b1000);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule